// File: doc/BRIEF.md
# Double-Word Field Extract/Insert Unit

This block pulls a bit field out of a pair of 32-bit words, or writes a field into a word, under the control of a small descriptor. The descriptor has three parts: a shift count, a field width and a mode bit. The two data words are joined with the high word on top and the low word below. The 64-bit value is shifted left by the shift count, and the upper half is kept as the shifted word.

In extract mode the shifted word is masked down to its lowest `fwidth` bits, which gives a right-justified field. In insert mode the mask is also cleared below the shift count. Masked positions then take the shifted word, and every other position keeps the low word. Software-style bit-field reads and writes, rotates and funnel shifts can all be built from this one operation.

The unit has a fixed two-register pipeline. It captures the operands and descriptor when `in_vld` is high. It presents the result with a one-cycle `out_vld` pulse.

Top module: `field_merge_unit`

## Requirements
- R1: The shifted word equals bits 63..32 of `{hi_word, lo_word}` shifted left by `shamt` (0 to 31). With `fwidth` of 32 in extract mode, `result` equals this shifted word.
- R2: In extract mode (`ins_mode` = 0), `result` is the shifted word ANDed with a mask whose low `fwidth` bits are one. Any `fwidth` of 32 or more (field is 6 bits, 0 to 63) gives an all-ones mask.
- R3: In extract mode with `fwidth` = 0, `result` is zero.
- R4: In insert mode (`ins_mode` = 1), the mask from R2 also has bits below `shamt` cleared. `result` takes shifted-word bits where the mask is one and `lo_word` bits where it is zero.
- R5: In insert mode with `fwidth` = 0, or with `fwidth` no greater than `shamt`, `result` equals `lo_word` unchanged.
- R6: With `shamt` = 0, the shifted word is `hi_word`.
- R7: When `in_vld` is high at a rising edge, `out_vld` goes high after the next rising edge for exactly one cycle, and `result` holds that operation's value in that cycle. Back-to-back operations stream at one per cycle.
- R8: Inputs presented with `in_vld` low have no effect. `out_vld` stays low and `result` keeps its last value.
- R9: While `rst_n` is low at a rising edge, `out_vld` and `result` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operands and descriptor valid this cycle |
| hi_word | input | 32 | Upper word of the shifted pair |
| lo_word | input | 32 | Lower word; also the merge background in insert mode |
| shamt | input | 5 | Left shift count |
| fwidth | input | 6 | Field width; 32 and above means full word |
| ins_mode | input | 1 | 0 = extract, 1 = insert |
| out_vld | output | 1 | One-cycle result strobe |
| result | output | 32 | Extract or insert result |

## Verification
A wrong shifter stage appears at the ports as a displacement of the result by one power of two. It shows only for shift counts that have that bit set, so the directed shifts cover every bit of the count. A wrong mask bit corrupts a single result position. In insert mode it leaks shifted data into the preserved low bits. A broken capture or strobe register misaligns the result within two cycles of the operation, and the back-to-back stream exposes this at once.

// File: rtl/fmu_pkg.sv
// Package: shared types for the field merge unit.
// Assumes: nothing beyond the standard language.
package fmu_pkg;

    // Operating mode of one operation.
    typedef enum logic {
        FM_EXTRACT = 1'b0,
        FM_INSERT  = 1'b1
    } fm_mode_e;

endpackage

// File: rtl/fmu_dshift.sv
// Module: fmu_dshift
// Shifts the double word {hi, lo} left by sh and returns the upper half.
// The shifter is a logarithmic stage per shift-count bit.
// Assumes: DATA_W is a power of two, and sh spans 0..DATA_W-1.
module fmu_dshift #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] lo,
    input  logic [SH_W-1:0]   sh,
    output logic [DATA_W-1:0] shifted
);

    logic [2*DATA_W-1:0] stage [0:SH_W];

    assign stage[0] = {hi, lo};

    // One conditional shift by 2**s for each bit of the shift count.
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        assign stage[s+1] = sh[s] ? (stage[s] << (1 << s)) : stage[s];
    end

    assign shifted = stage[SH_W][2*DATA_W-1:DATA_W];

    // Guard: a zero shift count passes the upper word straight through.
    always_comb begin
        if (!$isunknown({sh, hi, shifted})) begin
            // R6
            zero_shift_pass_chk: assert ((sh != '0) || (shifted == hi));
        end
    end

endmodule

// File: rtl/fmu_maskgen.sv
// Module: fmu_maskgen
// Builds the field mask. Bit i is set while i < width. In insert mode,
// bits below the shift count are also cleared.
// Assumes: width may exceed DATA_W, which saturates to all ones.
module fmu_maskgen #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int FW_W  = SH_W + 1
) (
    input  logic [FW_W-1:0]   width,
    input  logic [SH_W-1:0]   sh,
    input  fmu_pkg::fm_mode_e mode,
    output logic [DATA_W-1:0] mask
);

    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] keep_hi;

    // Per-bit mask decode: thermometer for width, floor for shift.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign base[i]    = (int'(width) > i);
        assign keep_hi[i] = (i >= int'(sh));
    end

    assign mask = (mode == fmu_pkg::FM_INSERT) ? (base & keep_hi) : base;

    // Guard: in extract mode the mask has exactly min(width, DATA_W) ones.
    always_comb begin
        if (!$isunknown({width, sh, mode, mask})) begin
            // R2
            extract_ones_chk: assert ((mode != fmu_pkg::FM_EXTRACT) ||
                ($countones(mask) == ((int'(width) > DATA_W) ? DATA_W : int'(width))));
            // R4
            insert_floor_chk: assert ((mode != fmu_pkg::FM_INSERT) ||
                ((mask & ~({DATA_W{1'b1}} << sh)) == '0));
        end
    end

endmodule

// File: rtl/fmu_merge.sv
// Module: fmu_merge
// Selects shifted bits under the mask. The background outside the mask
// is zero in extract mode and the low word in insert mode.
// Assumes: mask already reflects the mode.
module fmu_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] shifted,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] mask,
    input  fmu_pkg::fm_mode_e mode,
    output logic [DATA_W-1:0] merged
);

    logic [DATA_W-1:0] background;

    // Background source chosen by mode.
    always_comb begin
        background = (mode == fmu_pkg::FM_INSERT) ? lo : '0;
        merged     = (shifted & mask) | (background & ~mask);
    end

    // Guard: outside the mask the output never carries shifted data.
    always_comb begin
        if (!$isunknown({shifted, lo, mask, mode, merged})) begin
            // R3
            extract_outside_chk: assert ((mode != fmu_pkg::FM_EXTRACT) ||
                ((merged & ~mask) == '0));
            // R5
            insert_outside_chk: assert ((mode != fmu_pkg::FM_INSERT) ||
                ((merged & ~mask) == (lo & ~mask)));
        end
    end

endmodule

// File: rtl/field_merge_unit.sv
// Module: field_merge_unit
// Double-word shift, mask and insert unit. It captures operands on in_vld,
// computes the result from the captured copy, and registers it with a
// one-cycle out_vld strobe.
// Assumes: synchronous active-low reset; one operation per cycle at most.
module field_merge_unit #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int FW_W  = SH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] hi_word,
    input  logic [DATA_W-1:0] lo_word,
    input  logic [SH_W-1:0]   shamt,
    input  logic [FW_W-1:0]   fwidth,
    input  logic              ins_mode,
    output logic              out_vld,
    output logic [DATA_W-1:0] result
);

    import fmu_pkg::*;

    logic              cap_vld;
    logic [DATA_W-1:0] cap_hi;
    logic [DATA_W-1:0] cap_lo;
    logic [SH_W-1:0]   cap_sh;
    logic [FW_W-1:0]   cap_w;
    fm_mode_e          cap_mode;

    logic [DATA_W-1:0] sh_word;
    logic [DATA_W-1:0] fmask;
    logic [DATA_W-1:0] merged;

    // Operand capture: load on in_vld, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld  <= 1'b0;
            cap_hi   <= '0;
            cap_lo   <= '0;
            cap_sh   <= '0;
            cap_w    <= '0;
            cap_mode <= FM_EXTRACT;
        end else begin
            cap_vld <= in_vld;
            if (in_vld) begin
                cap_hi   <= hi_word;
                cap_lo   <= lo_word;
                cap_sh   <= shamt;
                cap_w    <= fwidth;
                cap_mode <= fm_mode_e'(ins_mode);
            end
        end
    end

    fmu_dshift #(.DATA_W(DATA_W)) u_shift (
        .hi      (cap_hi),
        .lo      (cap_lo),
        .sh      (cap_sh),
        .shifted (sh_word)
    );

    fmu_maskgen #(.DATA_W(DATA_W)) u_mask (
        .width (cap_w),
        .sh    (cap_sh),
        .mode  (cap_mode),
        .mask  (fmask)
    );

    fmu_merge #(.DATA_W(DATA_W)) u_merge (
        .shifted (sh_word),
        .lo      (cap_lo),
        .mask    (fmask),
        .mode    (cap_mode),
        .merged  (merged)
    );

    // Result register: update only for a captured operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            result  <= '0;
        end else begin
            out_vld <= cap_vld;
            if (cap_vld) begin
                result <= merged;
            end
        end
    end

    // R7
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |=> out_vld);

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_vld |=> !out_vld);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(result));

    // R3
    empty_extract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && cap_w == '0 && cap_mode == FM_EXTRACT) |=> (result == '0));

    // R5
    empty_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && cap_w == '0 && cap_mode == FM_INSERT) |=> (result == $past(cap_lo)));

endmodule

// File: tb/test_field_merge_unit.sv
module test_field_merge_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [31:0] hi_word, lo_word;
    logic [4:0]  shamt;
    logic [5:0]  fwidth;
    logic        ins_mode;
    logic        out_vld;
    logic [31:0] result;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    field_merge_unit i_field_merge_unit (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .hi_word(hi_word), .lo_word(lo_word), .shamt(shamt),
        .fwidth(fwidth), .ins_mode(ins_mode),
        .out_vld(out_vld), .result(result)
    );

    // Reference computed from the requirement text.
    function automatic logic [31:0] ref_val(input logic [31:0] h, input logic [31:0] l,
                                            input logic [4:0] s, input logic [5:0] w,
                                            input logic ins);
        logic [63:0] pair;
        logic [31:0] sw, m;
        pair = {h, l} << s;
        sw   = pair[63:32];
        m    = (w >= 6'd32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        if (ins) begin
            m = m & (32'hFFFF_FFFF << s);
            return (sw & m) | (l & ~m);
        end
        return sw & m;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One isolated operation: strobe, then scramble the inputs, then check the pulse and the hold.
    task automatic run_one(input string tag, input logic [31:0] h, input logic [31:0] l,
                           input logic [4:0] s, input logic [5:0] w, input logic ins);
        logic [31:0] exp;
        exp = ref_val(h, l, s, w, ins);
        @(negedge clk);
        in_vld = 1'b1; hi_word = h; lo_word = l; shamt = s; fwidth = w; ins_mode = ins;
        @(negedge clk);
        in_vld = 1'b0; hi_word = ~h; lo_word = ~l; shamt = ~s; fwidth = ~w; ins_mode = ~ins;
        @(negedge clk);
        check({tag, " R7 strobe"}, {31'd0, out_vld}, 32'd1);
        check(tag, result, exp);
        @(negedge clk);
        check({tag, " R7 single pulse"}, {31'd0, out_vld}, 32'd0);
        check({tag, " R8 hold"}, result, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_vld = 1'b0; hi_word = '0; lo_word = '0;
        shamt = '0; fwidth = '0; ins_mode = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 out_vld", {31'd0, out_vld}, 32'd0);
        check("R9 result", result, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_shift;
        run_one("R6 zero shift", 32'hDEAD_BEEF, 32'h1234_5678, 5'd0, 6'd32, 1'b0);
        for (int k = 0; k < 5; k++)
            run_one("R1 shift", 32'hA5C3_0F81, 32'h7E19_B264, 5'(1 << k), 6'd32, 1'b0);
        run_one("R1 shift 31", 32'h0000_0001, 32'h8000_0000, 5'd31, 6'd32, 1'b0);
        run_one("R1 shift 13", 32'hCAFE_F00D, 32'h0BAD_1DEA, 5'd13, 6'd32, 1'b0);
    endtask

    task automatic t_extract;
        run_one("R3 width 0", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd7, 6'd0, 1'b0);
        run_one("R2 width 1", 32'hFFFF_FFFF, 32'h0, 5'd3, 6'd1, 1'b0);
        run_one("R2 width 12", 32'h1357_9BDF, 32'h2468_ACE0, 5'd8, 6'd12, 1'b0);
        run_one("R2 width 31", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 6'd31, 1'b0);
        run_one("R2 width 40", 32'h89AB_CDEF, 32'h0123_4567, 5'd20, 6'd40, 1'b0);
        run_one("R2 width 63", 32'h89AB_CDEF, 32'h0123_4567, 5'd4, 6'd63, 1'b0);
    endtask

    task automatic t_insert;
        run_one("R4 insert", 32'h0000_00AB, 32'hFFFF_FFFF, 5'd8, 6'd16, 1'b1);
        run_one("R4 insert full", 32'h1111_2222, 32'h3333_4444, 5'd4, 6'd32, 1'b1);
        run_one("R4 insert s0", 32'h0000_0F0F, 32'hAAAA_AAAA, 5'd0, 6'd8, 1'b1);
        run_one("R5 insert w0", 32'hFFFF_FFFF, 32'h5A5A_1234, 5'd9, 6'd0, 1'b1);
        run_one("R5 insert w<=s", 32'hFFFF_FFFF, 32'h5A5A_1234, 5'd10, 6'd10, 1'b1);
    endtask

    task automatic t_ignore;
        logic [31:0] prev;
        @(negedge clk);
        prev = result;
        in_vld = 1'b0; hi_word = 32'hFFFF_FFFF; lo_word = 32'h0F0F_0F0F;
        shamt = 5'd3; fwidth = 6'd32; ins_mode = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 idle out_vld", {31'd0, out_vld}, 32'd0);
        check("R8 idle result", result, prev);
    endtask

    task automatic t_stream;
        logic [31:0] exp_q [0:23];
        for (int c = 0; c < 26; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check("R7 stream strobe", {31'd0, out_vld}, 32'd1);
                check("R7 stream data", result, exp_q[c-2]);
            end
            if (c < 24) begin
                in_vld = 1'b1; hi_word = $urandom; lo_word = $urandom;
                shamt = 5'($urandom); fwidth = 6'($urandom); ins_mode = 1'($urandom);
                exp_q[c] = ref_val(hi_word, lo_word, shamt, fwidth, ins_mode);
            end else begin
                in_vld = 1'b0;
            end
        end
        @(negedge clk);
        check("R7 stream end", {31'd0, out_vld}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_shift();
        t_extract();
        t_insert();
        t_ignore();
        t_stream();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule